// File: doc/BRIEF.md
# AES Round Key Sequencer

This block supplies the round keys of the AES cipher, one 128-bit round key per clock. It serves a cipher datapath that consumes keys in forward order when encrypting and in reverse order when decrypting. The host always presents the key in its ordinary encryption form, with a size code for 128, 192 or 256 bits, and pulses a start strobe together with a direction bit.

The reverse order is not held as a table of round keys. The first time a key is used for decryption, the block steps the forward expansion to its end without emitting anything. It keeps the Nk-word window of expanded key words that begins at the last round key. It then walks the expansion backwards from that window, recovering each earlier word from two later ones. The cached window stays valid for as long as the key and size code stay the same. A later decryption therefore begins at once, and so does a decryption that follows a completed encryption under that key.

Top module: `aes_rkgen`

## Requirements
- R1: The size code on `key_size_i` selects the key length. Code 0 is a 128-bit key taken from `key_i[255:128]`, with 10 rounds. Code 1 is a 192-bit key from `key_i[255:64]`, with 12 rounds. Code 2 is a 256-bit key from all of `key_i`, with 14 rounds. Code 3 behaves as code 2. Key word 0 sits in the most significant 32 bits.
- R2: After a start accepted with `decrypt_i`=0, round keys 0 through Nr appear on consecutive cycles, starting in the cycle after the start edge. Each has `rk_valid_o`=1 and `rk_idx_o` equal to its round number. Each equals words 4k..4k+3 of the standard AES key expansion, with word 4k in `rk_o[127:96]`.
- R3: A decryption emits the same round-key values in the order Nr down to 0, one per cycle, and `rk_idx_o` counts down.
- R4: A decryption with no valid cached key first spends Nr+1 cycles with `rk_valid_o`=0 and `ready_o`=0, then emits its first key.
- R5: A decryption whose 256-bit key input and size code equal those of the last accepted start emits round key Nr in the cycle after the start edge. This holds once that earlier run has finished, whether it was an encryption or a decryption.
- R6: A start with a different key input or a different size code makes the cached key invalid. A decryption under it pays the delay of R4.
- R7: `ready_o` is 1 only while idle. It falls in the cycle after an accepted start and rises in the cycle after the last round key. A start raised while busy has no effect on the keys emitted and is not recorded as the current key.
- R8: After reset, `ready_o`=1, `rk_valid_o`=0 and no cached key is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_i | input | 256 | Encryption key, word 0 in the top bits |
| key_size_i | input | 2 | Key length code |
| start_i | input | 1 | Start strobe, taken when `ready_o` is 1 |
| decrypt_i | input | 1 | 1 selects reverse key order |
| rk_o | output | 128 | Current round key |
| rk_valid_o | output | 1 | `rk_o` holds a round key |
| rk_idx_o | output | 4 | Round number of `rk_o` |
| ready_o | output | 1 | Idle and able to accept a start |

## Verification
The block has no parameters, so the bench builds it as it stands and reaches every key length through the size code, including the alias code 3. Runs under a repeated key and under changed keys or sizes bring both the cached start and the derivation delay within reach. A start pulsed in the middle of a run shows whether it disturbs the sequence or the record of the current key. A known 128-bit key anchors the last forward round key to a fixed value.

// File: rtl/aes_rkgen.sv
module aes_rkgen (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [255:0] key_i,
  input  logic [1:0]   key_size_i,
  input  logic         start_i,
  input  logic         decrypt_i,
  output logic [127:0] rk_o,
  output logic         rk_valid_o,
  output logic [3:0]   rk_idx_o,
  output logic         ready_o
);

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ENC, S_DEC} st_t;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] sq, inv;
    sq  = gmul(x, x);
    inv = sq;
    for (int k = 0; k < 6; k++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [7:0] rcon(input logic [6:0] n);
    logic [7:0] c;
    c = 8'h01;
    for (int j = 1; j < 15; j++)
      if (7'(j) < n) c = {c[6:0], 1'b0} ^ (c[7] ? 8'h1b : 8'h00);
    return c;
  endfunction

  function automatic logic [31:0] kfun(input logic [6:0] i, input logic [31:0] x,
                                       input logic [1:0] sz);
    logic [6:0] md, dv;
    case (sz)
      2'd0:    begin md = i % 7'd4; dv = i / 7'd4; end
      2'd1:    begin md = i % 7'd6; dv = i / 7'd6; end
      default: begin md = i % 7'd8; dv = i / 7'd8; end
    endcase
    if (md == 7'd0)
      return subw({x[23:0], x[31:24]}) ^ {rcon(dv), 24'h0};
    else if (sz[1] && md == 7'd4)
      return subw(x);
    else
      return x;
  endfunction

  function automatic logic [3:0] nk_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 4'd4 : (sz == 2'd1) ? 4'd6 : 4'd8;
  endfunction

  function automatic logic [3:0] nr_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 4'd10 : (sz == 2'd1) ? 4'd12 : 4'd14;
  endfunction

  st_t          st;
  logic [3:0]   r;
  logic [31:0]  win   [8];
  logic [31:0]  cache [8];
  logic [31:0]  fwd   [8];
  logic [31:0]  rev   [8];
  logic         cache_ok;
  logic [255:0] key_q;
  logic [1:0]   size_q;

  wire [3:0] nk    = nk_of(size_q);
  wire [3:0] nr    = nr_of(size_q);
  wire [3:0] nr_in = nr_of(key_size_i);
  wire [6:0] base  = {1'b0, r, 2'b00};
  wire       hit   = cache_ok && (key_i == key_q) && (key_size_i == size_q);

  always_comb begin : fwd_c
    logic [31:0] ext [12];
    logic [31:0] prev, nw;
    for (int k = 0; k < 12; k++) ext[k] = '0;
    for (int k = 0; k < 8; k++)
      if (4'(k) < nk) ext[k] = win[k];
    prev = win[3'(nk - 4'd1)];
    for (int m = 0; m < 4; m++) begin
      nw = win[m] ^ kfun(7'(base + 7'(nk) + 7'(m)), prev, size_q);
      ext[4'(nk + 4'(m))] = nw;
      prev = nw;
    end
    for (int k = 0; k < 8; k++) fwd[k] = ext[k + 4];
  end

  always_comb begin : rev_c
    logic [31:0] rec [4];
    logic [31:0] pw;
    logic [3:0]  t;
    for (int m = 0; m < 4; m++) rec[m] = '0;
    for (int m = 3; m >= 0; m--) begin
      t  = 4'(m) + nk;
      pw = (t == 4'd4) ? rec[3] : win[3'(t - 4'd5)];
      rec[m] = win[3'(t - 4'd4)] ^ kfun(7'(base + 7'(t) - 7'd4), pw, size_q);
    end
    for (int k = 0; k < 8; k++) rev[k] = (k < 4) ? rec[k] : win[k - 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      r        <= '0;
      cache_ok <= 1'b0;
      key_q    <= '0;
      size_q   <= '0;
      for (int k = 0; k < 8; k++) begin
        win[k]   <= '0;
        cache[k] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          key_q  <= key_i;
          size_q <= key_size_i;
          if (decrypt_i && hit) begin
            win <= cache;
            r   <= nr_in;
            st  <= S_DEC;
          end else begin
            for (int k = 0; k < 8; k++) win[k] <= key_i[255 - 32*k -: 32];
            r  <= '0;
            st <= decrypt_i ? S_PREP : S_ENC;
            if (!hit) cache_ok <= 1'b0;
          end
        end
        S_PREP: if (r == nr) begin
          cache    <= win;
          cache_ok <= 1'b1;
          st       <= S_DEC;
        end else begin
          win <= fwd;
          r   <= r + 4'd1;
        end
        S_ENC: if (r == nr) begin
          cache    <= win;
          cache_ok <= 1'b1;
          st       <= S_IDLE;
        end else begin
          win <= fwd;
          r   <= r + 4'd1;
        end
        default: if (r == 4'd0) begin
          st <= S_IDLE;
        end else begin
          win <= rev;
          r   <= r - 4'd1;
        end
      endcase
    end
  end

  assign rk_o       = {win[0], win[1], win[2], win[3]};
  assign rk_valid_o = (st == S_ENC) || (st == S_DEC);
  assign rk_idx_o   = r;
  assign ready_o    = (st == S_IDLE);

endmodule

// File: rtl/aes_rkgen_chk.sv
module aes_rkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       ready_o,
  input logic       rk_valid_o,
  input logic [3:0] rk_idx_o
);

  p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid_o |-> !ready_o);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ready_o);

  p_end_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rk_valid_o) |-> ready_o);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && $past(rk_valid_o)) |->
      (rk_idx_o == $past(rk_idx_o) + 4'd1 || rk_idx_o == $past(rk_idx_o) - 4'd1));

  p_first_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rk_valid_o) |->
      (rk_idx_o == 4'd0 || rk_idx_o == 4'd10 || rk_idx_o == 4'd12 || rk_idx_o == 4'd14));

  p_idx_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid_o |-> rk_idx_o <= 4'd14);

endmodule

bind aes_rkgen aes_rkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .rk_valid_o(rk_valid_o), .rk_idx_o(rk_idx_o)
);

// File: tb/aes_rkgen_tb.sv
`timescale 1ns/1ps
module aes_rkgen_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key_i = '0;
  logic [1:0]   key_size_i = '0;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] rk_o;
  logic         rk_valid_o;
  logic [3:0]   rk_idx_o;
  logic         ready_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]   sb [256];
  logic [31:0]  ew [64];
  logic [127:0] last_rk;
  bit           m_ok = 0;
  logic [255:0] m_key = '0;
  logic [1:0]   m_size = '0;

  always #4 clk = ~clk;

  aes_rkgen u_dut (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .key_size_i(key_size_i),
    .start_i(start_i), .decrypt_i(decrypt_i), .rk_o(rk_o),
    .rk_valid_o(rk_valid_o), .rk_idx_o(rk_idx_o), .ready_o(ready_o)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mulg(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = '0;
    logic [7:0] aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc ^= aa;
      aa = xt(aa);
    end
    return acc;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = '0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (mulg(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int b = 0; b < 8; b++)
        s[b] = s[b] ^ inv[b] ^ inv[(b + 4) % 8] ^ inv[(b + 5) % 8] ^
               inv[(b + 6) % 8] ^ inv[(b + 7) % 8];
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic int nk_of(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;
  endfunction

  function automatic int nr_of(input logic [1:0] s);
    return nk_of(s) + 6;
  endfunction

  task automatic expand(input logic [255:0] key, input logic [1:0] size);
    int nk = nk_of(size);
    int tot = 4 * (nr_of(size) + 1);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 64; i++) ew[i] = '0;
    for (int i = 0; i < nk; i++) ew[i] = key[255 - 32*i -: 32];
    for (int i = nk; i < tot; i++) begin
      logic [31:0] t = ew[i - 1];
      if (i % nk == 0) begin
        t = sw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = xt(rc);
      end else if (nk == 8 && i % 8 == 4) begin
        t = sw(t);
      end
      ew[i] = ew[i - nk] ^ t;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [255:0] key, input logic [1:0] size,
                        input bit dec, input bit poke);
    int nr = nr_of(size);
    bit hit = m_ok && key == m_key && size == m_size;
    string tag;
    expand(key, size);
    @(negedge clk);
    check(ready_o == 1'b1, "R7 ready before start", 128'(ready_o), 128'd1);
    key_i = key; key_size_i = size; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (dec && !hit) begin
      tag = m_ok ? "R6 invalidated cache delay" : "R4 R8 derivation delay";
      for (int c = 0; c <= nr; c++) begin
        check(rk_valid_o == 1'b0 && ready_o == 1'b0, tag,
              128'({rk_valid_o, ready_o}), 128'd0);
        @(negedge clk);
      end
    end
    for (int k = 0; k <= nr; k++) begin
      int idx = dec ? nr - k : k;
      logic [127:0] exp = {ew[4*idx], ew[4*idx+1], ew[4*idx+2], ew[4*idx+3]};
      tag = !dec ? "R1 R2 forward key" : (hit ? "R5 cached reverse key" : "R3 reverse key");
      check(rk_valid_o == 1'b1 && rk_idx_o == 4'(idx), tag,
            128'({rk_valid_o, rk_idx_o}), 128'({1'b1, 4'(idx)}));
      check(rk_o == exp, tag, rk_o, exp);
      last_rk = rk_o;
      if (poke && k == 2) begin
        key_i = ~key; key_size_i = 2'(size + 2'd1); decrypt_i = ~dec; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(rk_valid_o == 1'b0 && ready_o == 1'b1, "R7 idle after last key",
          128'({rk_valid_o, ready_o}), 128'd1);
    m_ok = 1; m_key = key; m_size = size;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] ka, kb, kfips;
    logic [255:0] prev_key;
    logic [1:0]   prev_size;
    void'($urandom(32'd2718));
    build_sbox();
    repeat (3) @(negedge clk);
    check(ready_o == 1'b1 && rk_valid_o == 1'b0, "R8 reset state",
          128'({ready_o, rk_valid_o}), 128'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1 && rk_valid_o == 1'b0, "R8 idle after reset",
          128'({ready_o, rk_valid_o}), 128'd2);

    kfips = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    run_op(kfips, 2'd0, 1'b0, 1'b0);
    check(last_rk == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R2 known last key",
          last_rk, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    run_op(kfips, 2'd0, 1'b1, 1'b0);

    ka = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    kb = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    run_op(ka, 2'd2, 1'b1, 1'b0);
    run_op(ka, 2'd2, 1'b1, 1'b0);
    run_op(ka, 2'd1, 1'b1, 1'b0);
    run_op(kb, 2'd1, 1'b1, 1'b0);
    run_op(kb, 2'd1, 1'b0, 1'b1);
    run_op(kb, 2'd1, 1'b1, 1'b0);
    run_op(ka, 2'd3, 1'b0, 1'b0);
    run_op(ka, 2'd3, 1'b1, 1'b1);

    prev_key = ka; prev_size = 2'd3;
    for (int n = 0; n < 40; n++) begin
      logic [255:0] k;
      logic [1:0]   s;
      if ($urandom % 2 == 0) begin
        k = prev_key; s = prev_size;
      end else begin
        k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        s = 2'($urandom % 4);
      end
      run_op(k, s, 1'($urandom % 2), ($urandom % 5) == 0);
      prev_key = k; prev_size = s;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule